// File: doc/BRIEF.md
# Count-Min Frequency Sketch Engine

This block keeps an approximate frequency table for a stream of sample values. It holds a set of rows, each a bank of saturating counters. Every row owns a small affine hash that maps a sample onto one bucket of that row. An update command bumps the chosen bucket in every row at once. A query command reads the chosen bucket of every row and reports the smallest of those counts. Hash collisions can only raise a count, so that smallest count is the best available estimate of how often the sample has been seen.

The query minimum is reduced by a registered pairwise comparison tree, one register stage per level. A query therefore answers after a fixed delay, and a new query may be issued on every cycle. The per-row hash coefficients can be rewritten at run time, one row per cycle, so that callers can reseed the hashes between measurement windows.

Top module: `cms_engine`

## Requirements
- R1: After reset every counter reads zero, row r has hash coefficients a = 2r+1 and b = r, and `res_valid_o` and `res_min_o` are zero.
- R2: Opcode 1 (update) adds one to exactly one counter in each row: the one at bucket (a_r * sample + b_r) mod BUCKETS.
- R3: Opcode 2 (query) produces the smallest of the ROWS counters selected by that same hash, zero-extended to the 64-bit `res_min_o`.
- R4: Each query produces exactly one result cycle, with `res_valid_o` high, exactly clog2(ROWS)+1 cycles after the cycle in which the query was presented. Queries on consecutive cycles give results on consecutive cycles, in issue order.
- R5: A counter that holds its all-ones value (255 at the default width) stays there when it is updated again. It does not wrap.
- R6: Opcode 0 (idle) and opcode 3 change no counter and produce no result.
- R7: A coefficient write (`coef_we_i` high, with row, a and b) takes effect from the next cycle. An update or query in the same cycle still uses the previous coefficients of that row.
- R8: A query sees every update presented in earlier cycles. Updates presented after the query do not change its result.
- R9: When ROWS is not a power of two, the missing leaves of the tree behave as all-ones counters and so never win the minimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 2 | Command: 0 idle, 1 update, 2 query, 3 ignored |
| sample_i | input | SMP_W | Sample value that is hashed |
| coef_we_i | input | 1 | Write strobe for one row's hash coefficients |
| coef_row_i | input | clog2(ROWS) | Row whose coefficients are written |
| coef_a_i | input | COEF_W | New multiplier coefficient |
| coef_b_i | input | COEF_W | New offset coefficient |
| res_valid_o | output | 1 | One-cycle pulse marking a query result |
| res_min_o | output | RES_W | Minimum selected count, zero-extended |

## Verification
Two pairs of functions can fall in the same cycle. In the first pair, a coefficient write lands together with an update. The bench drives both in one cycle, then queries under both the old and the new hash. Its model applies the update with the old coefficients before it installs the new ones, and the results are judged against that model. In the second pair, updates to a sample are issued in the cycles right after a query of that sample, while the query is still in the tree. The scoreboard entry is frozen at issue time, so any of those later updates that leaked into the result would show up as a mismatch.

// File: rtl/cms_pkg.sv
package cms_pkg;
   localparam logic [1:0] OP_IDLE   = 2'd0;
   localparam logic [1:0] OP_UPDATE = 2'd1;
   localparam logic [1:0] OP_QUERY  = 2'd2;
endpackage

// File: rtl/cms_hash.sv
module cms_hash #(
   parameter int SMP_W   = 16,
   parameter int COEF_W  = 8,
   parameter int BUCKETS = 13,
   parameter int IDX_W   = 4,
   parameter logic [COEF_W-1:0] A_RST = '0,
   parameter logic [COEF_W-1:0] B_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [COEF_W-1:0] a_i,
   input  logic [COEF_W-1:0] b_i,
   input  logic [SMP_W-1:0]  sample_i,
   output logic [IDX_W-1:0]  idx_o
);
   localparam int PROD_W = SMP_W + COEF_W + 1;

   logic [COEF_W-1:0] a_q, b_q;
   logic [PROD_W-1:0] lin;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_q <= A_RST;
         b_q <= B_RST;
      end else if (we_i) begin
         a_q <= a_i;
         b_q <= b_i;
      end
   end

   assign lin = PROD_W'(a_q) * PROD_W'(sample_i) + PROD_W'(b_q);

   generate
      if ((BUCKETS & (BUCKETS - 1)) == 0) begin : g_pow2
         assign idx_o = lin[IDX_W-1:0];
      end else begin : g_mod
         logic [PROD_W-1:0] rem;
         assign rem   = lin % PROD_W'(BUCKETS);
         assign idx_o = rem[IDX_W-1:0];
      end
   endgenerate

   // R7: coefficients change only on a write strobe
   a_r7_coef_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> ($stable(a_q) && $stable(b_q)));
endmodule

// File: rtl/cms_row.sv
module cms_row #(
   parameter int BUCKETS = 13,
   parameter int CNT_W   = 8,
   parameter int IDX_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q [BUCKETS];

   generate
      for (genvar k = 0; k < BUCKETS; k++) begin : g_bkt
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt_q[k] <= '0;
            else if (inc_i && (idx_i == IDX_W'(k)) && (cnt_q[k] != CNT_MAX))
               cnt_q[k] <= cnt_q[k] + 1'b1;
         end

         // R5: a saturated counter never wraps
         a_r5_sat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q[k] == CNT_MAX) |=> (cnt_q[k] == CNT_MAX));

         // R2: a counter moves by at most one per cycle
         a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q[k] != CNT_MAX) |=>
               ((cnt_q[k] == $past(cnt_q[k])) || (cnt_q[k] == $past(cnt_q[k]) + 1'b1)));

         // R6: without an increment the counter holds
         a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !inc_i |=> $stable(cnt_q[k]));
      end
   endgenerate

   assign cnt_o = (int'(idx_i) < BUCKETS) ? cnt_q[idx_i] : CNT_MAX;
endmodule

// File: rtl/cms_min_tree.sv
module cms_min_tree #(
   parameter int ROWS  = 5,
   parameter int CNT_W = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       load_i,
   input  logic [ROWS-1:0][CNT_W-1:0] leaf_i,
   output logic                       valid_o,
   output logic [CNT_W-1:0]           min_o
);
   localparam int LEVELS = $clog2(ROWS);
   localparam int PAD    = 1 << LEVELS;

   logic [PAD-1:0][CNT_W-1:0] stg_q [LEVELS+1];
   logic [LEVELS:0]           vld_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q    <= '0;
         stg_q[0] <= '0;
      end else begin
         vld_q[0] <= load_i;
         if (load_i) begin
            for (int p = 0; p < PAD; p++)
               stg_q[0][p] <= (p < ROWS) ? leaf_i[p % ROWS] : '1;
         end
      end
   end

   generate
      for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
         localparam int NODES = PAD >> l;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld_q[l] <= 1'b0;
               stg_q[l] <= '0;
            end else begin
               vld_q[l] <= vld_q[l-1];
               if (vld_q[l-1]) begin
                  for (int n = 0; n < PAD; n++) begin
                     if (n < NODES)
                        stg_q[l][n] <= (stg_q[l-1][(2*n+1) % PAD] < stg_q[l-1][(2*n) % PAD])
                                       ? stg_q[l-1][(2*n+1) % PAD] : stg_q[l-1][(2*n) % PAD];
                     else
                        stg_q[l][n] <= '1;
                  end
               end
            end
         end

         // R4: a result advances one level per cycle
         a_r4_valid_walk: assert property (@(posedge clk) disable iff (!rst_n)
            vld_q[l-1] |=> vld_q[l]);

         // R3: a node never exceeds either of its children
         a_r3_node_min: assert property (@(posedge clk) disable iff (!rst_n)
            vld_q[l-1] |=> ((stg_q[l][0] <= $past(stg_q[l-1][0])) &&
                            (stg_q[l][0] <= $past(stg_q[l-1][1]))));
      end

      if (PAD > ROWS) begin : g_pad
         // R9: padded leaves load as all-ones
         a_r9_pad_max: assert property (@(posedge clk) disable iff (!rst_n)
            load_i |=> (stg_q[0][PAD-1] == {CNT_W{1'b1}}));
      end
   endgenerate

   assign valid_o = vld_q[LEVELS];
   assign min_o   = stg_q[LEVELS][0];
endmodule

// File: rtl/cms_engine.sv
module cms_engine #(
   parameter int ROWS    = 5,
   parameter int BUCKETS = 13,
   parameter int CNT_W   = 8,
   parameter int SMP_W   = 16,
   parameter int COEF_W  = 8,
   parameter int RES_W   = 64,
   localparam int ROW_W  = $clog2(ROWS),
   localparam int IDX_W  = $clog2(BUCKETS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        op_i,
   input  logic [SMP_W-1:0]  sample_i,
   input  logic              coef_we_i,
   input  logic [ROW_W-1:0]  coef_row_i,
   input  logic [COEF_W-1:0] coef_a_i,
   input  logic [COEF_W-1:0] coef_b_i,
   output logic              res_valid_o,
   output logic [RES_W-1:0]  res_min_o
);
   import cms_pkg::*;

   generate
      if (ROWS < 2)        begin : g_chk_rows  $error("ROWS must be at least 2"); end
      if (BUCKETS < 2)     begin : g_chk_bkt   $error("BUCKETS must be at least 2"); end
      if (RES_W < CNT_W)   begin : g_chk_res   $error("RES_W narrower than CNT_W"); end
      if (COEF_W < ROW_W + 1) begin : g_chk_coef $error("COEF_W too narrow for reset seeds"); end
   endgenerate

   logic                       do_upd, do_qry;
   logic [ROWS-1:0][CNT_W-1:0] leaf;
   logic [CNT_W-1:0]           tree_min;

   assign do_upd = (op_i == OP_UPDATE);
   assign do_qry = (op_i == OP_QUERY);

   generate
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         logic [IDX_W-1:0] idx;
         logic             we;
         assign we = coef_we_i && (coef_row_i == ROW_W'(r));

         cms_hash #(
            .SMP_W(SMP_W), .COEF_W(COEF_W), .BUCKETS(BUCKETS), .IDX_W(IDX_W),
            .A_RST(COEF_W'(2*r + 1)), .B_RST(COEF_W'(r))
         ) hash_i (
            .clk(clk), .rst_n(rst_n), .we_i(we), .a_i(coef_a_i), .b_i(coef_b_i),
            .sample_i(sample_i), .idx_o(idx)
         );

         cms_row #(.BUCKETS(BUCKETS), .CNT_W(CNT_W), .IDX_W(IDX_W)) row_i (
            .clk(clk), .rst_n(rst_n), .inc_i(do_upd), .idx_i(idx), .cnt_o(leaf[r])
         );

         // R2: every hash lands inside its row
         a_r2_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
            do_upd |-> (int'(idx) < BUCKETS));
      end
   endgenerate

   cms_min_tree #(.ROWS(ROWS), .CNT_W(CNT_W)) tree_i (
      .clk(clk), .rst_n(rst_n), .load_i(do_qry), .leaf_i(leaf),
      .valid_o(res_valid_o), .min_o(tree_min)
   );

   assign res_min_o = RES_W'(tree_min);

   // R6: a result is never produced during the first cycles after reset
   a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !res_valid_o);
endmodule

// File: tb/cms_engine_tb_top.sv
module cms_engine_tb_top;
   localparam int ROWS = 5, BUCKETS = 13, SMP_W = 16, COEF_W = 8, RES_W = 64;
   localparam int LAT  = $clog2(ROWS) + 1;
   localparam int CMAX = 255;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [1:0] op_i = '0;
   logic [SMP_W-1:0] sample_i = '0;
   logic coef_we_i = 1'b0;
   logic [2:0] coef_row_i = '0;
   logic [COEF_W-1:0] coef_a_i = '0, coef_b_i = '0;
   logic res_valid_o;
   logic [RES_W-1:0] res_min_o;

   always #4 clk = ~clk;   // 125 MHz

   cms_engine dut_i (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .sample_i(sample_i),
      .coef_we_i(coef_we_i), .coef_row_i(coef_row_i), .coef_a_i(coef_a_i),
      .coef_b_i(coef_b_i), .res_valid_o(res_valid_o), .res_min_o(res_min_o)
   );

   int n_chk = 0, n_fail = 0, cyc = 0;
   int cnt_m [ROWS][BUCKETS];
   int a_m [ROWS], b_m [ROWS];
   int exp_q [$], cyc_q [$];
   string tag_q [$];

   always @(posedge clk) cyc <= cyc + 1;

   function automatic int bkt(int r, int x);
      return (a_m[r] * x + b_m[r]) % BUCKETS;
   endfunction

   function automatic int model_min(int x);
      int m = CMAX;
      for (int r = 0; r < ROWS; r++) if (cnt_m[r][bkt(r, x)] < m) m = cnt_m[r][bkt(r, x)];
      return m;
   endfunction

   task automatic check(string tag, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic drive(logic [1:0] op, int x, string tag = "",
                        bit we = 0, int row = 0, int a = 0, int b = 0);
      op_i = op; sample_i = SMP_W'(x); coef_we_i = we;
      coef_row_i = 3'(row); coef_a_i = COEF_W'(a); coef_b_i = COEF_W'(b);
      if (op == 2'd2) begin
         exp_q.push_back(model_min(x)); cyc_q.push_back(cyc); tag_q.push_back(tag);
      end
      if (op == 2'd1)
         for (int r = 0; r < ROWS; r++)
            if (cnt_m[r][bkt(r, x)] < CMAX) cnt_m[r][bkt(r, x)]++;
      if (we) begin a_m[row] = a; b_m[row] = b; end
      @(negedge clk);
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && res_valid_o) begin
         if (exp_q.size() == 0) begin
            check("R6 unexpected result", 1, 0);
         end else begin
            int e, c; string t;
            e = exp_q.pop_front(); c = cyc_q.pop_front(); t = tag_q.pop_front();
            check({t, " value"}, longint'(res_min_o), e);
            check("R4 latency", cyc - c, LAT);
         end
      end
   end

   initial begin
      repeat (400000) @(posedge clk);
      check("watchdog expired", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      for (int r = 0; r < ROWS; r++) begin
         a_m[r] = 2*r + 1; b_m[r] = r;
         for (int k = 0; k < BUCKETS; k++) cnt_m[r][k] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check("R1 valid after reset", res_valid_o, 0);
      check("R1 result after reset", longint'(res_min_o), 0);
      drive(2'd2, 100, "R1");
      drive(2'd2, 65535, "R1");
      // R2 / R3: updates of several patterns then queries
      for (int i = 0; i < 40; i++) drive(2'd1, (i * 37) % 9);
      for (int i = 0; i < 9; i++) drive(2'd2, i, "R3");
      drive(2'd1, 1234); drive(2'd1, 1234); drive(2'd1, 4321);
      drive(2'd2, 1234, "R2"); drive(2'd2, 4321, "R2"); drive(2'd2, 999, "R2");
      // R6: idle and opcode 3 neither count nor answer
      drive(2'd3, 1234); drive(2'd0, 1234); drive(2'd3, 4321);
      repeat (LAT + 2) drive(2'd0, 0);
      drive(2'd2, 1234, "R6"); drive(2'd2, 4321, "R6");
      // R7: coefficient write in the same cycle as an update
      drive(2'd1, 500, "", 1, 0, 7, 3);
      drive(2'd2, 500, "R7");
      drive(2'd1, 500, "", 1, 4, 11, 9);
      drive(2'd2, 500, "R7"); drive(2'd2, 501, "R7");
      // R8: update right before query, more updates while it is in flight
      drive(2'd1, 4242);
      drive(2'd2, 4242, "R8");
      drive(2'd1, 4242); drive(2'd1, 4242);
      drive(2'd2, 4242, "R8");
      // R4: back-to-back queries
      for (int i = 0; i < 6; i++) drive(2'd2, 1234 + i, "R4");
      // R5 / R9: saturation, padding must not mask a full minimum
      for (int i = 0; i < 260; i++) drive(2'd1, 777);
      drive(2'd2, 777, "R5");
      drive(2'd1, 777);
      drive(2'd2, 777, "R9");
      repeat (LAT + 4) drive(2'd0, 0);
      check("R4 every query answered", exp_q.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule